// File: doc/BRIEF.md
# Synchronous ROM Read Controller

This block sequences read accesses to a synchronous read-only array. The interface is sampled on each rising clock edge, in the manner of an SDRAM. A host issues three commands: a mode write, a row open and a column read. The block decodes them, enforces the timing rules between them and produces, for every beat of a read burst, the array address, a data-valid strobe and an output-enable. The array itself is a plain synchronous lookup outside the block, addressed by `arr_addr_o`.

Clock enable is registered. A low level seen at one edge freezes the whole block at the following edge. Used between reads, this is a power-down that keeps the open row and the mode. Used during a read, it pauses the burst, which resumes where it left off. Each read also carries a width select, which is held for the whole burst and passed to the output stage, and a data mask that gates the output-enable.

Top module: `srom_rdctl`

## Requirements
- R1: After reset the mode is CAS latency 5, sequential order and burst length 4, no row is open, and `dvalid_o`, `oe_o`, `illegal_o` and `reject_o` are low. A row open followed by a read works with no mode write first.
- R2: A command is taken only at an active edge (the previous cycle's `cke_i` was high) with `cke_i` high and `cs_n_i` low. Command codes on `op_i` are: 00 no-op, 01 row open (row in `addr_i`), 10 read (column in `addr_i[CW-1:0]`), 11 mode write. With `cs_n_i` high the code has no effect.
- R3: An edge whose previous `cke_i` was low is frozen. Inputs other than `cke_i` are ignored, and all state and outputs hold.
- R4: Clock enable dropped during a read pauses the burst. The burst continues afterwards and still delivers every beat in order.
- R5: A non-no-op command with `cs_n_i` low and `cke_i` low at an active edge is ignored and raises `illegal_o` after that edge.
- R6: The mode word is taken from `addr_i` as follows: [1:0] burst length code (0,1,2,3 give 1,2,4,8 beats), [2] interleaved order when 1, [5:3] CAS latency from 1 to 7, where 0 acts as 1.
- R7: For the three active edges after an accepted mode write, every command is rejected with `reject_o`. The fourth active edge accepts again.
- R8: A read is rejected unless a row open was accepted at least TRCD active edges earlier. Any command is rejected from the read edge until `dvalid_o` has fallen.
- R9: `dvalid_o` rises after the CL-th active edge that follows the read edge. It stays high for exactly BL active cycles.
- R10: `arr_addr_o` is {row, column}. Beat i uses the column (base & ~(BL-1)) | ((base+i) mod BL) in sequential order and base XOR i in interleaved order.
- R11: `wide_i` is sampled with the read and shows on `arr_wide_o` for every beat of that burst.
- R12: `dmask_i` high before active edge A forces `oe_o` low after the next active edge. `dvalid_o` is not affected. Otherwise `oe_o` equals `dvalid_o`.
- R13: A power-down keeps the open row and the mode. A read after wake-up needs no new row open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke_i | input | 1 | Clock enable, acts one edge later |
| cs_n_i | input | 1 | Chip select, active low |
| op_i | input | 2 | Command code |
| addr_i | input | AW | Row, column or mode word |
| wide_i | input | 1 | Width select for a read: 1 = 32-bit, 0 = 16-bit |
| dmask_i | input | 1 | Output mask |
| arr_addr_o | output | RW+CW | Array address {row, column} |
| arr_wide_o | output | 1 | Width of the current burst |
| dvalid_o | output | 1 | Beat valid strobe |
| oe_o | output | 1 | Output enable |
| illegal_o | output | 1 | Command seen with clock enable falling |
| reject_o | output | 1 | Command refused by a timing rule |

## Verification
The hardest case to reach is a clock-enable pause that lands inside a burst. The burst must resume with no lost or repeated beat, and a mask must take effect exactly one active edge after it is sampled. The read stimulus therefore carries per-cycle clock-enable and mask patterns. The bench follows them with its own count of active edges, derives the expected strobe, beat address and output-enable from that count, and places freezes both in the latency gap and between beats.

// File: rtl/srom_pkg.sv
package srom_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_ACT  = 2'b01,
    OP_RD   = 2'b10,
    OP_MODE = 2'b11
  } op_e;

  // field order follows the mode word on addr[5:0]
  typedef struct packed {
    logic [2:0] cl;
    logic       ilv;
    logic [1:0] bl;
  } mode_t;

  localparam mode_t MODE_RST = '{cl: 3'd5, ilv: 1'b0, bl: 2'd2};
endpackage

// File: rtl/srom_cmd_dec.sv
module srom_cmd_dec
  import srom_pkg::*;
#(
  parameter int RW   = 12,
  parameter int CW   = 8,
  parameter int AW   = 12,
  parameter int TRCD = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke,
  input  logic          cs_n,
  input  op_e           op,
  input  logic [AW-1:0] addr,
  input  logic          busy_i,
  output logic          en_o,
  output mode_t         mode_o,
  output logic [RW-1:0] row_o,
  output logic          rd_go_o,
  output logic [CW-1:0] rd_col_o,
  output logic          illegal_o,
  output logic          reject_o
);
  localparam int TW = $clog2(TRCD + 1);

  logic          cke_q;
  logic          row_vld;
  logic [TW-1:0] gap;
  logic [1:0]    blk;
  logic          live, want, ok;

  assign en_o     = cke_q;
  assign live     = cke_q && !cs_n && (op != OP_NOP);
  assign want     = live && cke;
  assign rd_go_o  = want && ok && (op == OP_RD);
  assign rd_col_o = addr[CW-1:0];

  always_comb begin
    ok = 1'b0;
    if (blk == 2'd0 && !busy_i) begin
      case (op)
        OP_MODE: ok = 1'b1;
        OP_ACT:  ok = 1'b1;
        OP_RD:   ok = row_vld && (int'(gap) >= TRCD - 1);
        default: ok = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q     <= 1'b1;
      mode_o    <= MODE_RST;
      row_o     <= '0;
      row_vld   <= 1'b0;
      gap       <= '0;
      blk       <= 2'd0;
      illegal_o <= 1'b0;
      reject_o  <= 1'b0;
    end else begin
      cke_q <= cke;
      if (cke_q) begin
        illegal_o <= live && !cke;
        reject_o  <= want && !ok;
        if (blk != 2'd0) blk <= blk - 2'd1;
        if (int'(gap) < TRCD) gap <= gap + 1'b1;
        if (want && ok) begin
          case (op)
            OP_MODE: begin
              mode_o <= mode_t'(addr[5:0]);
              blk    <= 2'd3;
            end
            OP_ACT: begin
              row_o   <= addr[RW-1:0];
              row_vld <= 1'b1;
              gap     <= '0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    !cke_q |=> ($stable(mode_o) && $stable(row_o) && $stable(blk)));

  assert_blackout_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(blk != 2'd0) |-> $past(op == OP_MODE && !cs_n && cke));
endmodule

// File: rtl/srom_burst.sv
module srom_burst
  import srom_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  mode_t         mode,
  input  logic          go,
  input  logic [CW-1:0] col,
  input  logic          wide,
  input  logic          dmask,
  output logic          busy_o,
  output logic [CW-1:0] col_o,
  output logic          wide_o,
  output logic          dvalid_o,
  output logic          oe_o
);
  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_BEAT} ph_e;

  ph_e           ph;
  logic [2:0]    wait_c, beat, nbeat, last;
  logic [CW-1:0] base;
  logic          dm_q, nvalid;

  function automatic logic [CW-1:0] beat_col(input logic [CW-1:0] b,
                                             input logic [2:0] i,
                                             input logic il,
                                             input logic [2:0] m);
    logic [CW-1:0] mk, off;
    mk  = CW'(m);
    off = il ? (b ^ CW'(i)) : (b + CW'(i));
    return (b & ~mk) | (off & mk);
  endfunction

  assign last   = 3'((4'd1 << mode.bl) - 4'd1);
  assign busy_o = (ph != PH_IDLE);

  always_comb begin
    nvalid = 1'b0;
    nbeat  = beat;
    if (ph == PH_WAIT && wait_c == 3'd0) begin
      nvalid = 1'b1;
      nbeat  = 3'd0;
    end else if (ph == PH_BEAT && beat != last) begin
      nvalid = 1'b1;
      nbeat  = beat + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      wait_c   <= 3'd0;
      beat     <= 3'd0;
      base     <= '0;
      col_o    <= '0;
      wide_o   <= 1'b0;
      dvalid_o <= 1'b0;
      oe_o     <= 1'b0;
      dm_q     <= 1'b0;
    end else if (en) begin
      dm_q     <= dmask;
      dvalid_o <= nvalid;
      oe_o     <= nvalid && !dm_q;
      beat     <= nbeat;
      if (nvalid) col_o <= beat_col(base, nbeat, mode.ilv, last);
      case (ph)
        PH_IDLE: if (go) begin
          ph     <= PH_WAIT;
          wait_c <= (mode.cl == 3'd0) ? 3'd0 : mode.cl - 3'd1;
          base   <= col;
          wide_o <= wide;
        end
        PH_WAIT: if (wait_c == 3'd0) ph <= PH_BEAT;
                 else wait_c <= wait_c - 3'd1;
        PH_BEAT: if (beat == last) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assert_oe_in_beat_R12: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> dvalid_o);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dvalid_o) && $stable(col_o) && $stable(beat)));

  assert_first_beat_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(dvalid_o) |-> $past(ph == PH_WAIT));
endmodule

// File: rtl/srom_rdctl.sv
module srom_rdctl
  import srom_pkg::*;
#(
  parameter int RW   = 12,
  parameter int CW   = 8,
  parameter int AW   = 12,
  parameter int TRCD = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke_i,
  input  logic            cs_n_i,
  input  logic [1:0]      op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wide_i,
  input  logic            dmask_i,
  output logic [RW+CW-1:0] arr_addr_o,
  output logic            arr_wide_o,
  output logic            dvalid_o,
  output logic            oe_o,
  output logic            illegal_o,
  output logic            reject_o
);
  logic          en, busy, rd_go;
  mode_t         mode;
  logic [RW-1:0] row;
  logic [CW-1:0] rd_col, col;

  srom_cmd_dec #(.RW(RW), .CW(CW), .AW(AW), .TRCD(TRCD)) u_dec (
    .clk(clk), .rst(rst), .cke(cke_i), .cs_n(cs_n_i), .op(op_e'(op_i)),
    .addr(addr_i), .busy_i(busy), .en_o(en), .mode_o(mode), .row_o(row),
    .rd_go_o(rd_go), .rd_col_o(rd_col), .illegal_o(illegal_o),
    .reject_o(reject_o)
  );

  srom_burst #(.CW(CW)) u_burst (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .go(rd_go), .col(rd_col),
    .wide(wide_i), .dmask(dmask_i), .busy_o(busy), .col_o(col),
    .wide_o(arr_wide_o), .dvalid_o(dvalid_o), .oe_o(oe_o)
  );

  assign arr_addr_o = {row, col};

  assert_row_steady_R10: assert property (@(posedge clk) disable iff (rst)
    (dvalid_o && busy) |=> $stable(row));
endmodule

// File: tb/srom_rdctl_tb.sv
module srom_rdctl_tb;
  localparam int RW = 12, CW = 8, AW = 12, TRCD = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, wide = 1'b0, dmask = 1'b0;
  logic [1:0] op = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [RW+CW-1:0] arr_addr;
  logic arr_wide, dvalid, oe, illegal, reject;
  int checks = 0, fails = 0;

  // {cl[2:0], ilv, bl[1:0], col[7:0], wide}
  localparam logic [14:0] VEC [0:5] = '{
    {3'd2, 1'b0, 2'd3, 8'h0d, 1'b1},
    {3'd1, 1'b1, 2'd2, 8'h26, 1'b0},
    {3'd3, 1'b0, 2'd1, 8'h11, 1'b1},
    {3'd7, 1'b1, 2'd3, 8'h35, 1'b0},
    {3'd1, 1'b0, 2'd0, 8'hff, 1'b1},
    {3'd0, 1'b0, 2'd2, 8'h03, 1'b0}
  };

  srom_rdctl #(.RW(RW), .CW(CW), .AW(AW), .TRCD(TRCD)) u_dut (
    .clk(clk), .rst(rst), .cke_i(cke), .cs_n_i(cs_n), .op_i(op),
    .addr_i(addr), .wide_i(wide), .dmask_i(dmask), .arr_addr_o(arr_addr),
    .arr_wide_o(arr_wide), .dvalid_o(dvalid), .oe_o(oe),
    .illegal_o(illegal), .reject_o(reject)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic nop();
    cke = 1'b1; cs_n = 1'b1; op = 2'b00; dmask = 1'b0;
  endtask

  // one command at the next edge, then no-op
  task automatic cmd(input logic [1:0] c, input logic [AW-1:0] a);
    cke = 1'b1; cs_n = 1'b0; op = c; addr = a;
    tick();
    nop();
  endtask

  // read with per-cycle clock-enable and mask patterns
  task automatic rd(input logic [RW-1:0] row, input logic [7:0] col,
                    input logic w, input int cl, input int bl,
                    input logic ilv, input logic [31:0] ckp,
                    input logic [31:0] dmp, input string tag);
    int n = 0, clx, beat;
    logic prev = 1'b1, dmq = 1'b0, dv = 1'b0, eo = 1'b0;
    logic [7:0] start, ec;
    clx = (cl == 0) ? 1 : cl;
    wide = w;
    cmd(2'b10, AW'(col));
    chk({tag, " read accepted"}, reject, 0);
    chk({tag, " dvalid low at read edge R9"}, dvalid, 0);
    for (int j = 0; j < 32; j++) begin
      cke = ckp[j]; dmask = dmp[j];
      tick();
      if (prev) begin
        n++;
        dv = (n >= clx) && (n < clx + bl);
        eo = dv && !dmq;
        dmq = dmp[j];
      end
      prev = ckp[j];
      chk({tag, " dvalid R9 R4"}, dvalid, dv);
      chk({tag, " oe R12"}, oe, eo);
      if (dv) begin
        beat = n - clx;
        start = col - (col % 8'(bl));
        ec = ilv ? (start + ((col % 8'(bl)) ^ 8'(beat)))
                 : (start + 8'(((col % 8'(bl)) + 8'(beat)) % 8'(bl)));
        chk({tag, " address R10"}, arr_addr, {row, ec});
        chk({tag, " width R11"}, arr_wide, w);
      end
    end
    nop();
    tick();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 reset dvalid", dvalid, 0);
    chk("R1 reset oe", oe, 0);
    chk("R1 reset illegal", illegal, 0);
    chk("R1 reset reject", reject, 0);

    // deselected mode write has no effect (R2)
    cke = 1'b1; cs_n = 1'b1; op = 2'b11; addr = 12'h008;
    tick(); nop();
    chk("R2 deselected ignored", reject, 0);

    // read without row is rejected (R8)
    cmd(2'b10, 12'h004);
    chk("R8 read without row", reject, 1);
    tick();

    cmd(2'b01, 12'h005);
    tick();
    rd(12'h005, 8'h04, 1'b1, 5, 4, 1'b0, '1, '0, "R1 default mode");

    // row-to-read spacing (R8)
    cmd(2'b01, 12'h0a1);
    cmd(2'b10, 12'h000);
    chk("R8 read too soon", reject, 1);
    rd(12'h0a1, 8'h00, 1'b0, 5, 4, 1'b0, '1, '0, "R8 read at spacing");

    // busy rejects (R8)
    cmd(2'b10, 12'h010);
    cmd(2'b10, 12'h020);
    chk("R8 read during latency", reject, 1);
    cmd(2'b11, 12'h02a);
    chk("R8 mode during burst", reject, 1);
    repeat (12) tick();

    // illegal command on falling clock enable (R5)
    cke = 1'b0; cs_n = 1'b0; op = 2'b01; addr = 12'h0aa;
    tick();
    nop();
    chk("R5 illegal flagged", illegal, 1);
    chk("R5 not rejected", reject, 0);
    tick();
    chk("R3 illegal held while frozen", illegal, 1);
    tick();
    chk("R5 illegal clears", illegal, 0);

    // command at a frozen edge ignored (R3)
    cke = 1'b0; tick();
    cke = 1'b1; cs_n = 1'b0; op = 2'b01; addr = 12'h0bb;
    tick(); nop();
    chk("R3 frozen no illegal", illegal, 0);
    chk("R3 frozen no reject", reject, 0);
    tick();
    rd(12'h0a1, 8'h08, 1'b1, 5, 4, 1'b0, '1, '0, "R3 R5 row kept");

    // power-down keeps row and mode (R13)
    cke = 1'b0; repeat (6) tick();
    nop(); repeat (2) tick();
    rd(12'h0a1, 8'h0c, 1'b0, 5, 4, 1'b0, '1, '0, "R13 after power-down");

    // suspend between beats and in latency (R4)
    rd(12'h0a1, 8'h02, 1'b1, 5, 4, 1'b0, ~32'h0000_0060, '0, "R4 mid-burst");
    rd(12'h0a1, 8'h01, 1'b0, 5, 4, 1'b0, ~32'h0000_000e, '0, "R4 in latency");

    // data mask (R12)
    rd(12'h0a1, 8'h05, 1'b1, 5, 4, 1'b0, '1, 32'h0000_0040, "R12 mask");
    rd(12'h0a1, 8'h05, 1'b1, 5, 4, 1'b0, ~32'h0000_0020, 32'h0000_0030, "R12 mask frozen");

    // mode blackout (R7)
    cmd(2'b11, 12'h02a);
    chk("R7 mode accepted", reject, 0);
    cmd(2'b01, 12'h033);
    chk("R7 blackout edge 1", reject, 1);
    tick();
    cmd(2'b01, 12'h033);
    chk("R7 blackout edge 3", reject, 1);
    cmd(2'b01, 12'h033);
    chk("R7 fourth edge accepts", reject, 0);

    // table of modes (R6 R9 R10 R11)
    for (int k = 0; k < 6; k++) begin
      logic [14:0] v;
      v = VEC[k];
      cmd(2'b11, {6'd0, v[14:12], v[11], v[10:9]});
      chk("R6 mode write", reject, 0);
      repeat (3) tick();
      cmd(2'b01, 12'h100 + 12'(k));
      tick();
      rd(12'h100 + 12'(k), v[8:1], v[0], int'(v[14:12]), 1 << v[10:9],
         v[11], '1, '0, "R6 R9 table");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule